// File: doc/BRIEF.md
# Parity-Guarded Fully Associative Translation Buffer

This block holds a small set of virtual-to-physical page translations in a fully associative array. Every entry stores a parity bit over its virtual page number (the tag) and a parity bit over its physical page number (the data). Each entry also has a lock flag. A lookup takes a valid strobe, a virtual page number and a side select. The side select says whether the request is an instruction fetch or a load/store. One clock later the block returns a registered hit and physical page.

An entry whose tag parity is wrong takes no part in matching, and a lock flag does not change this. Data parity is tested only on the entry chosen by the match. When that entry's data parity is wrong, the block returns no translation. In the same cycle it raises a precise access error on the requesting side, and that side's fault status register records the index of the failing entry. Each status register keeps its first error until it is cleared. Errors that arrive while it is still set only mark an overflow.

Entries are written either at an explicit index or at a replacement slot. The replacement slot is chosen by a round-robin pointer that steps over locked entries. Two write-time inputs can store a deliberately wrong tag or data parity bit, which lets error handling be exercised.

Top module: `tlb_parity_guard`

## Requirements
- R1: The lookup result is registered. rsp_valid equals lk_valid of the previous cycle. When rsp_valid is 0, rsp_hit, rsp_ppn, inst_acc_err and data_acc_err are all 0.
- R2: A lookup hits on the lowest-index entry that is valid, has correct tag parity and holds a virtual page equal to lk_vpn, and returns that entry's physical page. A miss gives rsp_hit=0 and rsp_ppn=0.
- R3: An entry stored with a wrong tag parity bit (wr_bad_tag_par=1) never matches. A lookup may then fall through to a higher-index duplicate of the same page.
- R4: A locked entry with a wrong tag parity bit also misses its own virtual page.
- R5: A wrong data parity bit in an entry that does not match the lookup has no effect on the result.
- R6: When the matching entry of an instruction-side lookup (lk_is_data=0) has wrong data parity, the result has rsp_hit=0, rsp_ppn=0 and inst_acc_err=1.
- R7: When the matching entry of a data-side lookup (lk_is_data=1) has wrong data parity, the result has rsp_hit=0, rsp_ppn=0 and data_acc_err=1.
- R8: In the cycle its side's access error is raised, a clear status register sets its err flag and captures the failing entry index.
- R9: While a side's err flag is set, another error on that side keeps the index and sets the ovf flag. A clear input resets err, ovf and index to 0. If a clear and an error arrive in the same cycle, the new error is captured as the first one, with ovf=0.
- R10: A write with wr_at_idx=1 replaces the entry at wr_idx, whether or not that entry is locked.
- R11: A write with wr_at_idx=0 goes to the first unlocked entry at or after the replacement pointer, scanning circularly, and the pointer then moves to the entry after it. If every entry is locked, the write is dropped.
- R12: After reset all entries are invalid and unlocked, the pointer is 0 and every output is 0. A lookup in the same cycle as a write sees the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write an entry this cycle |
| wr_at_idx | input | 1 | 1: write at wr_idx; 0: write at the replacement slot |
| wr_idx | input | IDX_W | Explicit entry index |
| wr_vpn | input | VPN_W | Virtual page to store |
| wr_ppn | input | PPN_W | Physical page to store |
| wr_lock | input | 1 | Lock flag to store |
| wr_bad_tag_par | input | 1 | Store an inverted tag parity bit |
| wr_bad_data_par | input | 1 | Store an inverted data parity bit |
| lk_valid | input | 1 | Lookup request strobe |
| lk_is_data | input | 1 | 0: instruction fetch; 1: load/store |
| lk_vpn | input | VPN_W | Virtual page to translate |
| ifs_clr | input | 1 | Clear the instruction-side fault status |
| dfs_clr | input | 1 | Clear the data-side fault status |
| rsp_valid | output | 1 | Registered lookup result valid |
| rsp_hit | output | 1 | Translation found with good parity |
| rsp_ppn | output | PPN_W | Physical page on hit, else 0 |
| inst_acc_err | output | 1 | Precise instruction access error |
| data_acc_err | output | 1 | Precise data access error |
| ifs_err | output | 1 | Instruction-side status: error captured |
| ifs_ovf | output | 1 | Instruction-side status: further error seen |
| ifs_idx | output | IDX_W | Instruction-side failing entry index |
| dfs_err | output | 1 | Data-side status: error captured |
| dfs_ovf | output | 1 | Data-side status: further error seen |
| dfs_idx | output | IDX_W | Data-side failing entry index |

## Verification
A corrupted entry array, parity bit or lock flag shows up on the first lookup that touches the affected page. It can appear as a wrong hit, a wrong physical page or a missing or spurious access error, one cycle after the request. A replacement pointer that skips wrongly goes unseen until a later lookup finds the wrong page evicted, so implicit writes are followed closely by lookups. A status register that overwrites or loses its first capture differs from the expected index or overflow flag in the cycle the second error lands.

// File: rtl/tlb_parity_guard.sv
module tlb_parity_guard #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_at_idx,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_lock,
  input  logic             wr_bad_tag_par,
  input  logic             wr_bad_data_par,
  input  logic             lk_valid,
  input  logic             lk_is_data,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             ifs_clr,
  input  logic             dfs_clr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic             inst_acc_err,
  output logic             data_acc_err,
  output logic             ifs_err,
  output logic             ifs_ovf,
  output logic [IDX_W-1:0] ifs_idx,
  output logic             dfs_err,
  output logic             dfs_ovf,
  output logic [IDX_W-1:0] dfs_idx
);

  logic [ENTRIES-1:0] e_valid, e_lock, e_tpar, e_dpar;
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [PPN_W-1:0]   e_ppn [ENTRIES];
  logic [IDX_W-1:0]   rp;

  logic [ENTRIES-1:0] match;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx;
  logic [PPN_W-1:0]   sel_ppn;
  logic               data_ok;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = e_valid[i] && ((^e_vpn[i]) == e_tpar[i]) && (e_vpn[i] == lk_vpn);
  end

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign sel_ppn = e_ppn[hit_idx];
  assign data_ok = (^sel_ppn) == e_dpar[hit_idx];

  wire good_hit = lk_valid && hit_any && data_ok;
  wire i_fault  = lk_valid && hit_any && !data_ok && !lk_is_data;
  wire d_fault  = lk_valid && hit_any && !data_ok && lk_is_data;

  logic             vic_found;
  logic [IDX_W-1:0] vic_idx;

  always_comb begin
    vic_found = 1'b0;
    vic_idx   = rp;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (!e_lock[(int'(rp) + k) % ENTRIES]) begin
        vic_found = 1'b1;
        vic_idx   = IDX_W'((int'(rp) + k) % ENTRIES);
      end
    end
  end

  wire             implicit_wr = wr_en && !wr_at_idx && vic_found;
  wire             do_wr       = (wr_en && wr_at_idx) || implicit_wr;
  wire [IDX_W-1:0] tgt         = wr_at_idx ? wr_idx : vic_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_valid <= '0;
      e_lock  <= '0;
      e_tpar  <= '0;
      e_dpar  <= '0;
      rp      <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_vpn[i] <= '0;
        e_ppn[i] <= '0;
      end
    end else begin
      if (do_wr) begin
        e_valid[tgt] <= 1'b1;
        e_lock[tgt]  <= wr_lock;
        e_vpn[tgt]   <= wr_vpn;
        e_ppn[tgt]   <= wr_ppn;
        e_tpar[tgt]  <= (^wr_vpn) ^ wr_bad_tag_par;
        e_dpar[tgt]  <= (^wr_ppn) ^ wr_bad_data_par;
      end
      if (implicit_wr) rp <= vic_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_ppn      <= '0;
      inst_acc_err <= 1'b0;
      data_acc_err <= 1'b0;
    end else begin
      rsp_valid    <= lk_valid;
      rsp_hit      <= good_hit;
      rsp_ppn      <= good_hit ? sel_ppn : '0;
      inst_acc_err <= i_fault;
      data_acc_err <= d_fault;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ifs_err <= 1'b0;
      ifs_ovf <= 1'b0;
      ifs_idx <= '0;
    end else begin
      if (ifs_clr) begin
        ifs_err <= 1'b0;
        ifs_ovf <= 1'b0;
        ifs_idx <= '0;
      end
      if (i_fault) begin
        if (ifs_clr || !ifs_err) begin
          ifs_err <= 1'b1;
          ifs_idx <= hit_idx;
          ifs_ovf <= 1'b0;
        end else begin
          ifs_ovf <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dfs_err <= 1'b0;
      dfs_ovf <= 1'b0;
      dfs_idx <= '0;
    end else begin
      if (dfs_clr) begin
        dfs_err <= 1'b0;
        dfs_ovf <= 1'b0;
        dfs_idx <= '0;
      end
      if (d_fault) begin
        if (dfs_clr || !dfs_err) begin
          dfs_err <= 1'b1;
          dfs_idx <= hit_idx;
          dfs_ovf <= 1'b0;
        end else begin
          dfs_ovf <= 1'b1;
        end
      end
    end
  end

endmodule

module tlb_parity_guard_chk #(
  parameter int PPN_W = 16,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             ifs_clr,
  input logic             dfs_clr,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [PPN_W-1:0] rsp_ppn,
  input logic             inst_acc_err,
  input logic             data_acc_err,
  input logic             ifs_err,
  input logic [IDX_W-1:0] ifs_idx,
  input logic             dfs_err,
  input logic [IDX_W-1:0] dfs_idx
);

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !inst_acc_err && !data_acc_err));

  // R2
  miss_zero_ppn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_ppn == '0);

  // R6
  err_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_acc_err || data_acc_err) |-> !rsp_hit);

  // R7
  one_side_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(inst_acc_err && data_acc_err));

  // R8
  ifs_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inst_acc_err |-> ifs_err);

  // R8
  dfs_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc_err |-> dfs_err);

  // R9
  ifs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ifs_err && !ifs_clr) |=> (ifs_err && ifs_idx == $past(ifs_idx)));

  // R9
  dfs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dfs_err && !dfs_clr) |=> (dfs_err && dfs_idx == $past(dfs_idx)));

endmodule

bind tlb_parity_guard tlb_parity_guard_chk #(.PPN_W(PPN_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .ifs_clr(ifs_clr), .dfs_clr(dfs_clr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
  .inst_acc_err(inst_acc_err), .data_acc_err(data_acc_err),
  .ifs_err(ifs_err), .ifs_idx(ifs_idx), .dfs_err(dfs_err), .dfs_idx(dfs_idx)
);

// File: tb/tlb_parity_guard_tb_top.sv
module tlb_parity_guard_tb_top;
  localparam int N = 8, VW = 20, PW = 16, IW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic wr_en = 0, wr_at_idx = 0, wr_lock = 0, wr_bad_tag_par = 0, wr_bad_data_par = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [VW-1:0] wr_vpn = '0, lk_vpn = '0;
  logic [PW-1:0] wr_ppn = '0;
  logic lk_valid = 0, lk_is_data = 0, ifs_clr = 0, dfs_clr = 0;
  logic rsp_valid, rsp_hit, inst_acc_err, data_acc_err, ifs_err, ifs_ovf, dfs_err, dfs_ovf;
  logic [PW-1:0] rsp_ppn;
  logic [IW-1:0] ifs_idx, dfs_idx;

  tlb_parity_guard #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW)) dut_i (.*);

  int total = 0, bad = 0;
  bit done = 0;

  bit m_valid[N], m_lock[N], m_tbad[N], m_dbad[N];
  int m_vpn[N], m_ppn[N];
  int rp;
  int e_rv, e_hit, e_ppn, e_iae, e_dae, e_ierr, e_iovf, e_iidx, e_derr, e_dovf, e_didx;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_lock[i] = 0; m_tbad[i] = 0; m_dbad[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0;
    end
    rp = 0;
    {e_rv, e_hit, e_ppn, e_iae, e_dae} = '0;
    {e_ierr, e_iovf, e_iidx, e_derr, e_dovf, e_didx} = '0;
  endtask

  task automatic model_step();
    int h, t;
    bit bd, okh, p;
    h = -1;
    for (int i = 0; i < N; i++)
      if (h < 0 && m_valid[i] && !m_tbad[i] && m_vpn[i] == int'(lk_vpn)) h = i;
    okh = (h >= 0) && !m_dbad[h];
    bd  = (h >= 0) && m_dbad[h];
    e_rv  = lk_valid;
    e_hit = lk_valid && okh;
    e_ppn = e_hit ? m_ppn[h] : 0;
    e_iae = lk_valid && bd && !lk_is_data;
    e_dae = lk_valid && bd && lk_is_data;
    p = e_ierr[0];
    if (ifs_clr) begin e_ierr = 0; e_iovf = 0; e_iidx = 0; end
    if (e_iae) begin
      if (ifs_clr || !p) begin e_ierr = 1; e_iidx = h; e_iovf = 0; end else e_iovf = 1;
    end
    p = e_derr[0];
    if (dfs_clr) begin e_derr = 0; e_dovf = 0; e_didx = 0; end
    if (e_dae) begin
      if (dfs_clr || !p) begin e_derr = 1; e_didx = h; e_dovf = 0; end else e_dovf = 1;
    end
    if (wr_en) begin
      t = -1;
      if (wr_at_idx) t = int'(wr_idx);
      else
        for (int k = 0; k < N; k++)
          if (t < 0 && !m_lock[(rp + k) % N]) t = (rp + k) % N;
      if (t >= 0) begin
        m_valid[t] = 1; m_lock[t] = wr_lock; m_vpn[t] = int'(wr_vpn); m_ppn[t] = int'(wr_ppn);
        m_tbad[t] = wr_bad_tag_par; m_dbad[t] = wr_bad_data_par;
        if (!wr_at_idx) rp = (t + 1) % N;
      end
    end
  endtask

  task automatic compare_all();
    chk("R1 rsp_valid", rsp_valid, e_rv);
    chk("R2 rsp_hit", rsp_hit, e_hit);
    chk("R2 rsp_ppn", rsp_ppn, e_ppn);
    chk("R6 inst_acc_err", inst_acc_err, e_iae);
    chk("R7 data_acc_err", data_acc_err, e_dae);
    chk("R8 ifs_err", ifs_err, e_ierr);
    chk("R8 ifs_idx", ifs_idx, e_iidx);
    chk("R9 ifs_ovf", ifs_ovf, e_iovf);
    chk("R8 dfs_err", dfs_err, e_derr);
    chk("R8 dfs_idx", dfs_idx, e_didx);
    chk("R9 dfs_ovf", dfs_ovf, e_dovf);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    wr_en = 0; lk_valid = 0; ifs_clr = 0; dfs_clr = 0;
    wr_bad_tag_par = 0; wr_bad_data_par = 0; wr_lock = 0; wr_at_idx = 0;
  endtask

  task automatic wr(bit at, int idx, int vpn, int ppn, bit lk, bit tb, bit db);
    wr_en = 1; wr_at_idx = at; wr_idx = IW'(idx); wr_vpn = VW'(vpn); wr_ppn = PW'(ppn);
    wr_lock = lk; wr_bad_tag_par = tb; wr_bad_data_par = db;
    cyc();
  endtask

  task automatic look(bit side, int vpn);
    lk_valid = 1; lk_is_data = side; lk_vpn = VW'(vpn);
    cyc();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 rsp_valid", rsp_valid, 0);
    chk("R12 ifs_err", ifs_err, 0);
    chk("R12 dfs_err", dfs_err, 0);
    rst_n = 1;
    // R11 fill through the pointer, locking 2 and 5
    for (int i = 0; i < N; i++) wr(0, 0, 'h100 + i, 'h40 + i, (i == 2 || i == 5), 0, 0);
    for (int i = 0; i < N; i++) begin look(i % 2, 'h100 + i); chk("R2 hit", rsp_ppn, 'h40 + i); end
    look(0, 'h3ff); chk("R2 miss", rsp_hit, 0);
    // R11 implicit writes skip locked 2
    wr(0, 0, 'h200, 'h90, 0, 0, 0);
    wr(0, 0, 'h201, 'h91, 0, 0, 0);
    wr(0, 0, 'h202, 'h92, 0, 0, 0);
    look(1, 'h202); chk("R11 skip locked", rsp_ppn, 'h92);
    look(1, 'h102); chk("R11 locked kept", rsp_ppn, 'h42);
    // R3 bad tag
    wr(1, 3, 'h103, 'h43, 0, 1, 0);
    look(0, 'h103); chk("R3 bad tag miss", rsp_hit, 0);
    // R4 locked bad tag, R10 explicit write of locked entry
    wr(1, 2, 'h102, 'h42, 1, 1, 0);
    look(1, 'h102); chk("R4 locked bad tag miss", rsp_hit, 0);
    // R2 duplicates, R3 fall through
    wr(1, 6, 'h104, 'h66, 0, 0, 0);
    look(0, 'h104); chk("R2 lowest index", rsp_ppn, 'h44);
    wr(1, 4, 'h104, 'h44, 0, 1, 0);
    look(0, 'h104); chk("R3 fall through", rsp_ppn, 'h66);
    // R5 bad data in non-matching entry
    wr(1, 7, 'h107, 'h47, 0, 0, 1);
    look(0, 'h105); chk("R5 other entry ok", rsp_ppn, 'h45);
    // R6 R8
    look(0, 'h107); chk("R6 iae", inst_acc_err, 1); chk("R8 idx", ifs_idx, 7);
    wr(1, 1, 'h301, 'h51, 0, 0, 1);
    look(0, 'h301); chk("R9 ovf", ifs_ovf, 1); chk("R9 idx held", ifs_idx, 7);
    // R7
    look(1, 'h301); chk("R7 dae", data_acc_err, 1); chk("R8 didx", dfs_idx, 1);
    // R9 clear, clear with error
    ifs_clr = 1; cyc(); chk("R9 clear", ifs_err, 0);
    ifs_clr = 1; look(0, 'h301); chk("R9 clr+err idx", ifs_idx, 1); chk("R9 clr+err ovf", ifs_ovf, 0);
    // R12 lookup vs same-cycle write
    wr_en = 1; wr_at_idx = 1; wr_idx = 0; wr_vpn = 'h500; wr_ppn = 'h77;
    lk_valid = 1; lk_is_data = 1; lk_vpn = 'h500; cyc();
    chk("R12 old contents", rsp_hit, 0);
    look(1, 'h500); chk("R10 new contents", rsp_ppn, 'h77);
    // R11 all locked -> drop
    for (int i = 0; i < N; i++) wr(1, i, 'h600 + i, 'h10 + i, 1, 0, 0);
    wr(0, 0, 'h7aa, 'h55, 0, 0, 0);
    look(0, 'h7aa); chk("R11 dropped", rsp_hit, 0);
    for (int i = 0; i < N; i++) begin look(1, 'h600 + i); chk("R11 intact", rsp_ppn, 'h10 + i); end
    // random phase
    for (int c = 0; c < 3000; c++) begin
      wr_en = ($urandom % 3) == 0; wr_at_idx = $urandom % 2; wr_idx = IW'($urandom);
      wr_vpn = VW'($urandom % 12); wr_ppn = PW'($urandom);
      wr_lock = ($urandom % 5) == 0; wr_bad_tag_par = ($urandom % 6) == 0;
      wr_bad_data_par = ($urandom % 6) == 0;
      lk_valid = $urandom % 2; lk_is_data = $urandom % 2; lk_vpn = VW'($urandom % 12);
      ifs_clr = ($urandom % 8) == 0; dfs_clr = ($urandom % 8) == 0;
      cyc();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule